// File: doc/BRIEF.md
# On-Die Temperature Sensor Sequencer

This block sits between a bus clock domain and an analog temperature-sensing macro. It drives the macro's three control pins: an active-high power-down, an active-low reset and an active-high run. The order in which they change, and the time spent in each step, is enforced in hardware. The controller accepts single-cycle enable and disable requests. It measures every dwell in ticks of a free-running timebase strobe, so the minimum times hold for any bus clock frequency as long as the strobe period is set correctly.

While the macro is running, the block repeatedly samples its 12-bit raw code. A multi-cycle restoring divider converts each sample to a signed reading in milli-degrees Celsius: the sample is multiplied by a fixed scale, divided with truncation by a fixed divisor, and then a fixed offset is subtracted. A one-cycle strobe marks each fresh reading. A valid flag is high only while the macro runs and at least one reading has completed. At all other times the reading port shows zero, which means no data. A status word repeats the current pin levels and the last sampled code at fixed bit positions, so software can decode it without a translation layer.

Top module: `tsense_seq`

## Requirements
- R1: After reset, power-down is 1, reset-not is 0, run is 0, valid is 0, the reading is 0, the done strobe is 0 and the status word equals 0x00000002.
- R2: An enable request while off starts this sequence: power-down alone held for at least PD_HOLD_TICKS ticks, then all three pins at 0 for at least PWRUP_TICKS ticks, then reset-not alone for at least SETTLE_TICKS ticks, then reset-not together with run. No other pin pattern appears in between.
- R3: Reset-not stays 0 for the whole power-up window. The window lasts at most PWRUP_TICKS+1 ticks. Whenever power-down is 1, reset-not and run are both 0.
- R4: A disable request while running gives exactly one cycle with run 0 and reset-not 1, then power-down alone.
- R5: A disable request received during any step of the enable sequence returns the pins to power-down alone in the next cycle. The sequence does not resume unless a new enable request arrives.
- R6: An enable request while running or mid-sequence, and a disable request while off, leave the pins and the reading unchanged.
- R7: Each reading equals floor(code × 237500 / 4094) − 81100, where code is the 12-bit unsigned raw input. Code 0 gives −81100 and code 4095 gives 156458.
- R8: Valid is 0 and the reading is 0 whenever run is 0. Valid is 1 from the first completed reading after run rises until run falls.
- R9: The done strobe lasts exactly one cycle per new reading. It never appears while run is 0.
- R10: The status word holds reset-not at bit 0, power-down at bit 1, run at bit 2 and the last sampled code at bits 27:16. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle timebase strobe that paces all dwell times |
| en_req_i | input | 1 | Enable request pulse |
| dis_req_i | input | 1 | Disable request pulse |
| raw_code_i | input | RAW_W | Raw conversion code from the macro |
| sens_pd_o | output | 1 | Macro power-down, 1 = powered down |
| sens_rstn_o | output | 1 | Macro reset, 0 = held in reset |
| sens_run_o | output | 1 | Macro conversion enable |
| status_o | output | STATUS_W | Status word: pin levels and last sampled code |
| temp_mc_o | output | TEMP_W | Signed reading in milli-degrees Celsius, 0 when not valid |
| temp_valid_o | output | 1 | Reading is valid |
| temp_done_o | output | 1 | One-cycle strobe for each new reading |

## Verification
The assertions assume that tick_i is a one-cycle strobe much slower than the clock. They also assume the raw code stays stable for the length of one division, because each division works on a registered copy taken when it starts. The bench produces ticks every fourth cycle from a free-running counter. It changes the raw code only while running, and then lets two results pass before it expects a reading for the new code. Requests are single-cycle pulses, driven on the falling edge so that each rising edge sees a stable value.

// File: rtl/tsense_pkg.sv
package tsense_pkg;

   typedef enum logic [2:0] {
      ST_OFF,
      ST_PD_HOLD,
      ST_PWRUP,
      ST_SETTLE,
      ST_RUN,
      ST_STOP
   } seq_state_e;

   // bit positions of the pin copies in the status word
   localparam int unsigned SW_RSTN = 0;
   localparam int unsigned SW_PD   = 1;
   localparam int unsigned SW_RUN  = 2;

endpackage

// File: rtl/tsense_dwell.sv
module tsense_dwell #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clear_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             expired_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clear_i) begin
         cnt_q <= '0;
      end else if (tick_i && (cnt_q != '1)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expired_o = (cnt_q >= limit_i);

endmodule

// File: rtl/tsense_ctrl.sv
module tsense_ctrl
   import tsense_pkg::*;
#(
   parameter int unsigned PD_HOLD_TICKS = 1,
   parameter int unsigned PWRUP_TICKS   = 60,
   parameter int unsigned SETTLE_TICKS  = 1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic en_req_i,
   input  logic dis_req_i,
   output logic pd_o,
   output logic rstn_o,
   output logic run_o
);

   localparam int unsigned MAX_T0 = (PD_HOLD_TICKS > PWRUP_TICKS) ? PD_HOLD_TICKS : PWRUP_TICKS;
   localparam int unsigned MAX_T  = (MAX_T0 > SETTLE_TICKS) ? MAX_T0 : SETTLE_TICKS;
   localparam int unsigned CNT_W  = $clog2(MAX_T + 2);

   if (PD_HOLD_TICKS < 1 || PWRUP_TICKS < 1 || SETTLE_TICKS < 1) begin : g_bad_dwell
      $error("tsense_ctrl: every dwell must be at least one tick");
   end

   seq_state_e       state_q, state_d;
   logic [CNT_W-1:0] limit;
   logic             expired;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_OFF:     if (en_req_i) state_d = ST_PD_HOLD;
         ST_PD_HOLD: if (dis_req_i) state_d = ST_OFF;
                     else if (expired) state_d = ST_PWRUP;
         ST_PWRUP:   if (dis_req_i) state_d = ST_OFF;
                     else if (expired) state_d = ST_SETTLE;
         ST_SETTLE:  if (dis_req_i) state_d = ST_OFF;
                     else if (expired) state_d = ST_RUN;
         ST_RUN:     if (dis_req_i) state_d = ST_STOP;
         ST_STOP:    state_d = ST_OFF;
         default:    state_d = ST_OFF;
      endcase
   end

   always_comb begin
      unique case (state_q)
         ST_PD_HOLD: limit = CNT_W'(PD_HOLD_TICKS);
         ST_PWRUP:   limit = CNT_W'(PWRUP_TICKS);
         ST_SETTLE:  limit = CNT_W'(SETTLE_TICKS);
         default:    limit = '0;
      endcase
   end

   tsense_dwell #(.CNT_W(CNT_W)) dwell_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clear_i   (state_d != state_q),
      .tick_i    (tick_i),
      .limit_i   (limit),
      .expired_o (expired)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= ST_OFF;
      else         state_q <= state_d;
   end

   always_comb begin
      pd_o   = 1'b0;
      rstn_o = 1'b0;
      run_o  = 1'b0;
      unique case (state_q)
         ST_OFF, ST_PD_HOLD: pd_o = 1'b1;
         ST_PWRUP:           ;
         ST_SETTLE, ST_STOP: rstn_o = 1'b1;
         ST_RUN:             begin rstn_o = 1'b1; run_o = 1'b1; end
         default:            pd_o = 1'b1;
      endcase
   end

   // independent tick count over the power-up window
   logic [CNT_W-1:0] win_ticks_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       win_ticks_q <= '0;
      else if (pd_o || rstn_o)           win_ticks_q <= '0;
      else if (tick_i && win_ticks_q != '1) win_ticks_q <= win_ticks_q + 1'b1;
   end

   // R3
   pwrup_dwell_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rstn_o) |-> (win_ticks_q >= CNT_W'(PWRUP_TICKS)));
   // R3
   rstn_after_pwrup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rstn_o) |-> (!pd_o && !$past(pd_o)));
   // R2
   run_after_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(run_o) |-> ($past(rstn_o) && !$past(pd_o)));
   // R4
   stop_keeps_rstn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(run_o) |-> (rstn_o && !pd_o));
   // R5
   pd_not_from_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pd_o) |-> (!run_o && !$past(run_o) && !rstn_o));

endmodule

// File: rtl/tsense_div.sv
module tsense_div #(
   parameter int unsigned RAW_W   = 12,
   parameter int unsigned SCALE   = 237500,
   parameter int unsigned DIVISOR = 4094,
   parameter int unsigned OFFSET  = 81100,
   parameter int unsigned TEMP_W  = 20
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     kill_i,
   input  logic                     start_i,
   input  logic [RAW_W-1:0]         raw_i,
   output logic                     busy_o,
   output logic                     done_o,
   output logic signed [TEMP_W-1:0] result_o
);

   localparam longint MAX_NUM = ((longint'(1) << RAW_W) - 1) * longint'(SCALE);
   localparam int unsigned NUM_W  = $clog2(MAX_NUM + 1);
   localparam int unsigned DEN_W  = $clog2(DIVISOR + 1);
   localparam int unsigned Q_W    = $clog2(MAX_NUM / DIVISOR + 1);
   localparam int unsigned STEP_W = $clog2(NUM_W + 1);

   if (TEMP_W < Q_W + 1) begin : g_bad_width
      $error("tsense_div: TEMP_W too narrow for the quotient plus sign");
   end
   if (DIVISOR < 1) begin : g_bad_div
      $error("tsense_div: divisor must be nonzero");
   end

   logic              busy_q, done_q;
   logic [STEP_W-1:0] step_q;
   logic [DEN_W-1:0]  rem_q;
   logic [NUM_W-1:0]  nq_q;
   logic signed [TEMP_W-1:0] res_q;

   logic [NUM_W-1:0] prod;
   logic [DEN_W:0]   trial, trial_sub;
   logic             fits;
   logic [NUM_W-1:0] nq_nx;
   logic [TEMP_W-1:0] q_ext;

   assign prod      = NUM_W'(raw_i) * NUM_W'(SCALE);
   assign trial     = {rem_q, nq_q[NUM_W-1]};
   assign fits      = (trial >= (DEN_W+1)'(DIVISOR));
   assign trial_sub = fits ? (trial - (DEN_W+1)'(DIVISOR)) : trial;
   assign nq_nx     = {nq_q[NUM_W-2:0], fits};
   assign q_ext     = TEMP_W'(nq_nx);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         step_q <= '0;
         rem_q  <= '0;
         nq_q   <= '0;
         res_q  <= '0;
      end else if (kill_i) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start_i && !busy_q) begin
            busy_q <= 1'b1;
            step_q <= '0;
            rem_q  <= '0;
            nq_q   <= prod;
         end else if (busy_q) begin
            rem_q  <= trial_sub[DEN_W-1:0];
            nq_q   <= nq_nx;
            step_q <= step_q + 1'b1;
            if (step_q == STEP_W'(NUM_W - 1)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               res_q  <= $signed(q_ext) - $signed(TEMP_W'(OFFSET));
            end
         end
      end
   end

   assign busy_o   = busy_q;
   assign done_o   = done_q;
   assign result_o = res_q;

   // R9
   done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |=> !done_q);
   // R7
   result_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |-> (res_q >= -$signed(TEMP_W'(OFFSET))));

endmodule

// File: rtl/tsense_seq.sv
module tsense_seq
   import tsense_pkg::*;
#(
   parameter int unsigned RAW_W         = 12,
   parameter int unsigned TEMP_W        = 20,
   parameter int unsigned SCALE         = 237500,
   parameter int unsigned DIVISOR       = 4094,
   parameter int unsigned OFFSET        = 81100,
   parameter int unsigned PD_HOLD_TICKS = 1,
   parameter int unsigned PWRUP_TICKS   = 60,
   parameter int unsigned SETTLE_TICKS  = 1,
   parameter int unsigned STATUS_W      = 32,
   parameter int unsigned RAW_LSB       = 16
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     tick_i,
   input  logic                     en_req_i,
   input  logic                     dis_req_i,
   input  logic [RAW_W-1:0]         raw_code_i,
   output logic                     sens_pd_o,
   output logic                     sens_rstn_o,
   output logic                     sens_run_o,
   output logic [STATUS_W-1:0]      status_o,
   output logic signed [TEMP_W-1:0] temp_mc_o,
   output logic                     temp_valid_o,
   output logic                     temp_done_o
);

   localparam int unsigned RAW_MSB = RAW_LSB + RAW_W - 1;

   if (RAW_MSB >= STATUS_W || RAW_LSB <= SW_RUN) begin : g_bad_layout
      $error("tsense_seq: raw field does not fit the status word");
   end
   if (TEMP_W < 20) begin : g_bad_temp
      $error("tsense_seq: reading must be at least 20 bits");
   end

   logic pd, rstn, run;
   logic div_busy, div_done, div_start;
   logic signed [TEMP_W-1:0] div_res;
   logic [RAW_W-1:0]         raw_q;
   logic signed [TEMP_W-1:0] temp_q;
   logic                     valid_q;

   tsense_ctrl #(
      .PD_HOLD_TICKS (PD_HOLD_TICKS),
      .PWRUP_TICKS   (PWRUP_TICKS),
      .SETTLE_TICKS  (SETTLE_TICKS)
   ) ctrl_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .en_req_i  (en_req_i),
      .dis_req_i (dis_req_i),
      .pd_o      (pd),
      .rstn_o    (rstn),
      .run_o     (run)
   );

   assign div_start = run && !div_busy && !div_done;

   tsense_div #(
      .RAW_W   (RAW_W),
      .SCALE   (SCALE),
      .DIVISOR (DIVISOR),
      .OFFSET  (OFFSET),
      .TEMP_W  (TEMP_W)
   ) div_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .kill_i   (!run),
      .start_i  (div_start),
      .raw_i    (raw_code_i),
      .busy_o   (div_busy),
      .done_o   (div_done),
      .result_o (div_res)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         raw_q   <= '0;
         temp_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         if (div_start) raw_q <= raw_code_i;
         if (!run) begin
            valid_q <= 1'b0;
         end else if (div_done) begin
            temp_q  <= div_res;
            valid_q <= 1'b1;
         end
      end
   end

   always_comb begin
      status_o                  = '0;
      status_o[SW_RSTN]         = rstn;
      status_o[SW_PD]           = pd;
      status_o[SW_RUN]          = run;
      status_o[RAW_MSB:RAW_LSB] = raw_q;
   end

   assign sens_pd_o    = pd;
   assign sens_rstn_o  = rstn;
   assign sens_run_o   = run;
   assign temp_valid_o = valid_q && run;
   assign temp_mc_o    = temp_valid_o ? temp_q : '0;
   assign temp_done_o  = div_done && run;

   // R8
   nodata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !temp_valid_o |-> (temp_mc_o == '0));
   // R9
   done_only_running_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      temp_done_o |=> (temp_valid_o || !sens_run_o));
   // R3
   pd_forces_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sens_pd_o |-> (!sens_rstn_o && !sens_run_o));

endmodule

// File: tb/tsense_seq_tb.sv
module tsense_seq_tb_top;

   localparam int PD_T  = 1;
   localparam int PU_T  = 60;
   localparam int ST_T  = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en_req = 1'b0, dis_req = 1'b0;
   logic [11:0] raw = '0;
   logic pd, rstn, run, valid, done;
   logic [31:0] status;
   logic signed [19:0] temp;
   logic [1:0] cyc = '0;
   logic tick;

   int n_tests = 0, n_fail = 0, n_done = 0;
   longint sb_q[$];

   always #2.5 clk = ~clk;
   always_ff @(posedge clk) cyc <= cyc + 1'b1;
   assign tick = (cyc == 2'd3);

   tsense_seq #(.PD_HOLD_TICKS(PD_T), .PWRUP_TICKS(PU_T), .SETTLE_TICKS(ST_T)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .en_req_i(en_req), .dis_req_i(dis_req),
      .raw_code_i(raw), .sens_pd_o(pd), .sens_rstn_o(rstn), .sens_run_o(run),
      .status_o(status), .temp_mc_o(temp), .temp_valid_o(valid), .temp_done_o(done));

   function automatic longint expect_mc(int code);
      return (longint'(code) * 237500) / 4094 - 81100;
   endfunction

   task automatic chk(string req, longint act, longint exp, string what);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [2:0] word();
      return {run, pd, rstn};
   endfunction

   // scoreboard monitor
   logic prev_done = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (done && prev_done) chk("R9", 1, 0, "done longer than one cycle");
         if (done && !run) chk("R9", 1, 0, "done while not running");
         if (done) begin
            n_done++;
            if (sb_q.size() > 0) begin
               automatic longint e = sb_q.pop_front();
               chk("R7", longint'(temp), e, "reading");
               chk("R8", valid, 1, "valid while running");
            end
         end
      end
      prev_done = done;
   end

   task automatic pulse_en();
      @(negedge clk) en_req = 1'b1;
      @(negedge clk) en_req = 1'b0;
   endtask
   task automatic pulse_dis();
      @(negedge clk) dis_req = 1'b1;
      @(negedge clk) dis_req = 1'b0;
   endtask

   task automatic enable_seq();
      int ph = 0, t0 = 0, t1 = 0, t2 = 0, bad = 0;
      pulse_en();
      for (int i = 0; i < 2000 && ph < 3; i++) begin
         case (ph)
            0: if (word() == 3'b000) ph = 1; else if (word() != 3'b010) bad++;
            1: if (word() == 3'b001) ph = 2; else if (word() != 3'b000) bad++;
            2: if (word() == 3'b101) ph = 3; else if (word() != 3'b001) bad++;
            default: ;
         endcase
         if (ph < 3 && tick) begin
            if (ph == 0) t0++; else if (ph == 1) t1++; else t2++;
         end
         if (ph < 3) @(negedge clk);
      end
      chk("R2", ph, 3, "reached running");
      chk("R2", bad, 0, "stray pin patterns");
      chk("R2", t0 >= PD_T, 1, "power-down hold ticks");
      chk("R3", t1 >= PU_T, 1, "power-up window ticks minimum");
      chk("R3", t1 <= PU_T + 1, 1, "power-up window ticks maximum");
      chk("R2", t2 >= ST_T, 1, "reset settle ticks");
   endtask

   task automatic convert(int code);
      int base;
      raw = 12'(code);
      base = n_done;
      for (int i = 0; i < 1000 && n_done < base + 2; i++) @(negedge clk);
      sb_q.push_back(expect_mc(code));
      for (int i = 0; i < 1000 && sb_q.size() > 0; i++) @(negedge clk);
      chk("R7", sb_q.size(), 0, "scoreboard drained");
      chk("R10", status, {4'h0, 12'(code), 13'h0, 3'b101}, "status word running");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int stay;
      repeat (3) @(negedge clk);
      // R1 reset values
      chk("R1", word(), 3'b010, "pins during reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", word(), 3'b010, "pins after reset");
      chk("R1", {valid, done}, 0, "valid and done");
      chk("R1", temp, 0, "reading");
      chk("R1", status, 32'h2, "status word");

      // R6 disable while off
      pulse_dis();
      stay = 0;
      for (int i = 0; i < 10; i++) begin if (word() != 3'b010) stay++; @(negedge clk); end
      chk("R6", stay, 0, "disable while off");

      enable_seq();
      chk("R8", valid, 0, "valid before first reading");
      chk("R8", temp, 0, "no-data before first reading");

      convert(0);
      convert(4095);
      convert(4094);
      convert(1);
      convert(2047);
      convert(1447);

      // R6 enable while running
      pulse_en();
      stay = 0;
      for (int i = 0; i < 40; i++) begin if (word() != 3'b101 || !valid) stay++; @(negedge clk); end
      chk("R6", stay, 0, "enable while running");

      // R4 disable from running
      @(negedge clk) dis_req = 1'b1;
      @(negedge clk) dis_req = 1'b0;
      chk("R4", word(), 3'b001, "stop step");
      chk("R8", {valid, temp != 0}, 0, "no data in stop step");
      @(negedge clk);
      chk("R4", word(), 3'b010, "powered down");
      stay = 0;
      for (int i = 0; i < 200; i++) begin if (valid || done || temp != 0) stay++; @(negedge clk); end
      chk("R8", stay, 0, "quiet while off");
      chk("R10", status[2:0], 3'b010, "status pins off");

      // R5 abort during power-up
      pulse_en();
      for (int i = 0; i < 100 && word() != 3'b000; i++) @(negedge clk);
      repeat (5) @(negedge clk);
      chk("R5", word(), 3'b000, "inside power-up");
      pulse_en();
      chk("R6", word(), 3'b000, "enable mid-sequence");
      @(negedge clk) dis_req = 1'b1;
      @(negedge clk) dis_req = 1'b0;
      chk("R5", word(), 3'b010, "abort to power-down");
      stay = 0;
      for (int i = 0; i < 400; i++) begin if (word() != 3'b010) stay++; @(negedge clk); end
      chk("R5", stay, 0, "no resume after abort");

      // R2 re-enable after abort
      enable_seq();
      convert(3000);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule